// File: doc/BRIEF.md
# Remote Framebuffer Command Bridge

This block lets a host push commands, parameters and pixel words to up to two external display controllers that sit on a shared 16-bit parallel bus. It also reads status or data words back from them. The host sees a word-wide register bus. A write to one of the panel-access registers becomes one or two 16-bit panel transfers. Each transfer carries a select line that marks it as a command (low) or as data (high), plus one chip-select bit per controller. The host access stalls until every selected controller has acknowledged every word.

A frame transfer is armed by writing the control register with the go bit set. While armed, the block shows a busy flag. Each data, read or status access decrements a pixel counter. When the counter reaches zero, busy clears and a one-cycle frame-done pulse is raised. Timing, data-cycle and sync-width registers are stored and masked for the controllers' use, but they do not shape the strobes here.

Register word addresses:
- 0: revision
- 1: system config
- 2: system status
- 3: control
- 4: pixel count
- 5: line
- 6: command
- 7: parameter
- 8: data
- 9: read-data
- 10: read-status
- 30: vsync width
- 31: hsync width

Per-chip bank k (k = 0 or 1) starts at 11 + 6k and holds, in order: config, on/off time, cycle time, and three data-cycle words.

Top module: `rfb_bridge`

## Requirements
- R1: After reset the registers read as follows: revision 0x10, system status 0x1, control 0x2, both config words 0x00310000, and the pixel count, line, timing, data-cycle and sync-width registers 0.
- R2: Writes are masked as follows:
  - config: 0x003f1fff
  - on/off time: 0x3fffffff
  - cycle time: 0x0fffffff
  - data-cycle: 0x0f1f0f1f
  - line: 11 bits
  - sync widths: 16 bits
  - system config: 0x19
  - control: low 4 bits only (bit 0 enable, bit 1 bypass, bits 2/3 select chip 0/1)
- R3: A write to the command register (6) sends its low 16 bits with the select line low to every chip whose control select bit is set. A write to the parameter register (7) does the same with the select line high. Chip-select bits never assert for a chip that is not selected.
- R4: A write to the data register (8) sends the low half and then the high half, both with the select line high, to every selected chip.
- R5: A panel access holds the word, the select line and the strobe until each selected chip has raised its acknowledge. A chip's chip-select bit drops once that chip has acknowledged. Host ready stays low until the last word is accepted.
- R6: A write to address 9 reads one word with the select line high, and a write to address 10 reads with it low. The lowest-numbered selected chip is used. The received word is then returned by host reads of addresses 9 and 10.
- R7: Each completed data, read-data or read-status access decrements the pixel count, wrapping from 0 to 0xffffffff. Reaching zero clears busy.
- R8: Writing control with bit 4 set sets busy only if the written enable bit is 1, the written bypass bit is 0, busy is clear, and bits 3:2 of the AND of both config words are 0. System status bit 8 shows busy.
- R9: When an access brings the count to zero while busy, frame_done is high for exactly one cycle, in the cycle after the access completes.
- R10: Writing system config with bit 1 set restores every R1 value except the received word. The idle field then takes the written value masked with 0x19.
- R11: With no chip selected, a panel access completes without any strobe, and the received word is left unchanged.
- R12: Addresses outside the map read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Register word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | Access completes at this clock edge |
| pnl_cs | output | 2 | Per-chip select, one bit per controller |
| pnl_a0 | output | 1 | 0 = command/status, 1 = data |
| pnl_wr | output | 1 | Write strobe |
| pnl_rd | output | 1 | Read strobe |
| pnl_wdata | output | 16 | Panel write word |
| pnl_rdata | input | 16 | Panel read word, valid with acknowledge |
| pnl_ack | input | 2 | Per-chip acknowledge of the current word |
| frame_done | output | 1 | One-cycle pulse at the end of an armed transfer |

## Verification
The bench aims at the following corner cases:
- Word order inside a data write. A swap would show up as high-before-low entries in the chip logs.
- The select-line value per access type.
- Read priority when both chips are selected. A wrong choice would read the higher chip.
- Accesses with no chip selected, which would hang or corrupt the received word if handled badly.
- Each of the four start-gate conditions, where a loose gate would set busy on a bypass write or a blocked config.
- The counter wrap at zero and the exact count at which busy clears and the single frame-done pulse appears.
- A slow chip that must stall the host.

// File: rtl/rfb_pkg.sv
// Shared constants and the panel-operation record for the framebuffer bridge.
package rfb_pkg;
    localparam int RFB_AW = 5;
    localparam int RFB_DW = 32;
    localparam int RFB_PW = 16;

    // Fixed register word addresses; per-chip banks start at A_BANK0.
    localparam int A_REV     = 0;
    localparam int A_SYSCFG  = 1;
    localparam int A_SYSSTAT = 2;
    localparam int A_CTRL    = 3;
    localparam int A_PIXCNT  = 4;
    localparam int A_LINE    = 5;
    localparam int A_CMD     = 6;
    localparam int A_PARAM   = 7;
    localparam int A_DATA    = 8;
    localparam int A_RDDATA  = 9;
    localparam int A_RDSTAT  = 10;
    localparam int A_BANK0   = 11;
    localparam int A_VSW     = 30;
    localparam int A_HSW     = 31;

    localparam logic [RFB_DW-1:0] REV_VAL    = 32'h0000_0010;
    localparam logic [RFB_DW-1:0] CFG_RST    = 32'h0031_0000;
    localparam logic [RFB_DW-1:0] CFG_MASK   = 32'h003f_1fff;
    localparam logic [RFB_DW-1:0] ONOFF_MASK = 32'h3fff_ffff;
    localparam logic [RFB_DW-1:0] CYC_MASK   = 32'h0fff_ffff;
    localparam logic [RFB_DW-1:0] DCYC_MASK  = 32'h0f1f_0f1f;
    localparam logic [RFB_DW-1:0] CFG_GATE   = 32'h0000_000c;
    localparam logic [4:0]        IDLE_MASK  = 5'h19;

    localparam int CB_EN    = 0;
    localparam int CB_BYP   = 1;
    localparam int CB_CHIP0 = 2;

    // One host-initiated panel operation.
    typedef struct packed {
        logic              rd;    // read strobe instead of write
        logic              two;   // two words: low half then high half
        logic              a0;    // command/data select level
        logic [RFB_DW-1:0] data;  // write payload
    } pnl_op_t;
endpackage

// File: rtl/rfb_panel_if.sv
// Panel sequencer: runs one latched operation as one or two 16-bit words.
// Each word is held until every chip in the latched mask has acknowledged it;
// a chip's select bit drops once it has acknowledged.
// Assumes op_start only arrives while idle and acknowledges come from selected chips.
module rfb_panel_if import rfb_pkg::*; #(
    parameter int NCHIP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  pnl_op_t           op_in,
    input  logic [NCHIP-1:0]  mask_in,
    output logic              op_done,
    output logic [NCHIP-1:0]  pnl_cs,
    output logic              pnl_a0,
    output logic              pnl_wr,
    output logic              pnl_rd,
    output logic [RFB_PW-1:0] pnl_wdata,
    input  logic [NCHIP-1:0]  pnl_ack
);
    logic             active_q;
    logic             hi_q;
    pnl_op_t          op_q;
    logic [NCHIP-1:0] mask_q;
    logic [NCHIP-1:0] acked_q;
    logic [NCHIP-1:0] got;
    logic [NCHIP-1:0] pending;
    logic             word_done;
    logic             last_word;

    // Per-chip select and acknowledge collection.
    for (genvar i = 0; i < NCHIP; i++) begin : g_chip
        assign pending[i] = mask_q[i] & ~acked_q[i];
        assign got[i]     = acked_q[i] | (pnl_ack[i] & mask_q[i]);
        assign pnl_cs[i]  = active_q & pending[i];
    end

    assign word_done = active_q && ((got & mask_q) == mask_q);
    assign last_word = !op_q.two || hi_q;
    assign op_done   = word_done && last_word;
    assign pnl_a0    = op_q.a0;
    assign pnl_wdata = hi_q ? op_q.data[RFB_DW-1:RFB_PW] : op_q.data[RFB_PW-1:0];
    assign pnl_wr    = active_q && !op_q.rd && (|pending);
    assign pnl_rd    = active_q &&  op_q.rd && (|pending);

    // Latch an operation, then step words as all selected chips acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hi_q     <= 1'b0;
            op_q     <= '0;
            mask_q   <= '0;
            acked_q  <= '0;
        end else if (op_start) begin
            active_q <= 1'b1;
            hi_q     <= 1'b0;
            op_q     <= op_in;
            mask_q   <= mask_in;
            acked_q  <= '0;
        end else if (active_q) begin
            if (word_done) begin
                acked_q <= '0;
                if (last_word) active_q <= 1'b0;
                else           hi_q     <= 1'b1;
            end else begin
                acked_q <= got;
            end
        end
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pnl_wr && pnl_rd));                                          // R3
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_rd |-> $countones(pnl_cs) == 1);                           // R6
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_wr && !word_done) |=> ($stable(pnl_wdata) && $stable(pnl_a0))); // R5
endmodule

// File: rtl/rfb_regfile.sv
// Register file and host-side control for the bridge: decodes host accesses,
// launches panel operations and stalls the host until they finish. It also keeps
// the pixel counter, the busy flag and the received word.
// Assumes the host holds its request stable until host_ready.
module rfb_regfile import rfb_pkg::*; #(
    parameter int NCHIP  = 2,
    parameter int LINE_W = 11,
    parameter int SYNC_W = 16,
    parameter int NDCYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [RFB_AW-1:0] host_addr,
    input  logic [RFB_DW-1:0] host_wdata,
    output logic [RFB_DW-1:0] host_rdata,
    output logic              host_ready,
    output logic              op_start,
    output pnl_op_t           op_out,
    output logic [NCHIP-1:0]  op_mask,
    input  logic              op_done,
    input  logic [RFB_PW-1:0] op_rdata,
    output logic [NCHIP-1:0]  chip_en,
    output logic              frame_done
);
    localparam int CTRL_W = CB_CHIP0 + NCHIP;
    localparam int CB_GO  = CTRL_W;
    localparam int STRIDE = 3 + NDCYC;

    logic [CTRL_W-1:0] ctrl_q;
    logic [RFB_DW-1:0] pix_q;
    logic [LINE_W-1:0] line_q;
    logic [4:0]        idle_q;
    logic [SYNC_W-1:0] vsw_q, hsw_q;
    logic [RFB_DW-1:0] cfg_q   [NCHIP];
    logic [RFB_DW-1:0] onoff_q [NCHIP];
    logic [RFB_DW-1:0] cyc_q   [NCHIP];
    logic [RFB_DW-1:0] dcyc_q  [NCHIP][NDCYC];
    logic              busy_q, fd_q, launched_q;
    logic [RFB_PW-1:0] rx_q;

    logic              is_panel, is_read, counted, acc, wr_acc, soft_rst, start_ok;
    logic [NCHIP-1:0]  rd_pick;
    logic [RFB_DW-1:0] cfg_and;

    function automatic logic [RFB_AW-1:0] bank_addr(input int k, input int off);
        return RFB_AW'(A_BANK0 + k * STRIDE + off);
    endfunction

    assign chip_en    = ctrl_q[CB_CHIP0 +: NCHIP];
    assign is_read    = (host_addr == RFB_AW'(A_RDDATA)) || (host_addr == RFB_AW'(A_RDSTAT));
    assign counted    = is_read || (host_addr == RFB_AW'(A_DATA));
    assign is_panel   = host_sel && host_wr &&
                        (counted || host_addr == RFB_AW'(A_CMD) || host_addr == RFB_AW'(A_PARAM));
    assign op_start   = is_panel && !launched_q;
    assign host_ready = host_sel && (!is_panel || (launched_q && op_done));
    assign acc        = host_sel && host_ready;
    assign wr_acc     = acc && host_wr;
    assign soft_rst   = wr_acc && host_addr == RFB_AW'(A_SYSCFG) && host_wdata[1];
    assign frame_done = fd_q;

    // Build the panel operation from the current request.
    always_comb begin
        op_out.rd   = is_read;
        op_out.two  = (host_addr == RFB_AW'(A_DATA));
        op_out.a0   = (host_addr != RFB_AW'(A_CMD)) && (host_addr != RFB_AW'(A_RDSTAT));
        op_out.data = host_wdata;
        op_mask     = is_read ? rd_pick : chip_en;
    end

    // Lowest-numbered selected chip wins a read.
    always_comb begin
        rd_pick = '0;
        for (int k = NCHIP - 1; k >= 0; k--)
            if (chip_en[k]) rd_pick = NCHIP'(1) << k;
    end

    // Start gate: AND of all config words must have the gate bits clear.
    always_comb begin
        cfg_and = '1;
        for (int k = 0; k < NCHIP; k++) cfg_and = cfg_and & cfg_q[k];
        start_ok = host_wdata[CB_GO] && host_wdata[CB_EN] && !host_wdata[CB_BYP] &&
                   !busy_q && ((cfg_and & CFG_GATE) == '0);
    end

    // Track whether the pending panel access has been launched.
    always_ff @(posedge clk) begin
        if (!rst_n || acc) launched_q <= 1'b0;
        else if (op_start) launched_q <= 1'b1;
    end

    // Capture the received word when a read with a selected chip completes.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else if (acc && is_panel && is_read && (|chip_en)) rx_q <= op_rdata;
    end

    // Register writes, soft reset, start gate and pixel counting.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= CTRL_W'(1 << CB_BYP);
            pix_q  <= '0;
            line_q <= '0;
            vsw_q  <= '0;
            hsw_q  <= '0;
            busy_q <= 1'b0;
            fd_q   <= 1'b0;
            idle_q <= rst_n ? (host_wdata[4:0] & IDLE_MASK) : 5'd0;
            for (int k = 0; k < NCHIP; k++) begin
                cfg_q[k]   <= CFG_RST;
                onoff_q[k] <= '0;
                cyc_q[k]   <= '0;
                for (int j = 0; j < NDCYC; j++) dcyc_q[k][j] <= '0;
            end
        end else begin
            fd_q <= 1'b0;
            if (wr_acc) begin
                if (host_addr == RFB_AW'(A_SYSCFG)) idle_q <= host_wdata[4:0] & IDLE_MASK;
                if (host_addr == RFB_AW'(A_CTRL)) begin
                    ctrl_q <= host_wdata[CTRL_W-1:0];
                    if (start_ok) busy_q <= 1'b1;
                end
                if (host_addr == RFB_AW'(A_PIXCNT)) pix_q  <= host_wdata;
                if (host_addr == RFB_AW'(A_LINE))   line_q <= host_wdata[LINE_W-1:0];
                if (host_addr == RFB_AW'(A_VSW))    vsw_q  <= host_wdata[SYNC_W-1:0];
                if (host_addr == RFB_AW'(A_HSW))    hsw_q  <= host_wdata[SYNC_W-1:0];
                for (int k = 0; k < NCHIP; k++) begin
                    if (host_addr == bank_addr(k, 0)) cfg_q[k]   <= host_wdata & CFG_MASK;
                    if (host_addr == bank_addr(k, 1)) onoff_q[k] <= host_wdata & ONOFF_MASK;
                    if (host_addr == bank_addr(k, 2)) cyc_q[k]   <= host_wdata & CYC_MASK;
                    for (int j = 0; j < NDCYC; j++)
                        if (host_addr == bank_addr(k, 3 + j)) dcyc_q[k][j] <= host_wdata & DCYC_MASK;
                end
                if (is_panel && counted) begin
                    pix_q <= pix_q - 1'b1;
                    if (pix_q == RFB_DW'(1)) begin
                        busy_q <= 1'b0;
                        fd_q   <= busy_q;
                    end
                end
            end
        end
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (int'(host_addr))
            A_REV:              host_rdata = REV_VAL;
            A_SYSCFG:           host_rdata = RFB_DW'(idle_q);
            A_SYSSTAT:          host_rdata = (RFB_DW'(busy_q) << 8) | RFB_DW'(1);
            A_CTRL:             host_rdata = RFB_DW'(ctrl_q);
            A_PIXCNT:           host_rdata = pix_q;
            A_LINE:             host_rdata = RFB_DW'(line_q);
            A_RDDATA, A_RDSTAT: host_rdata = RFB_DW'(rx_q);
            A_VSW:              host_rdata = RFB_DW'(vsw_q);
            A_HSW:              host_rdata = RFB_DW'(hsw_q);
            default:            host_rdata = '0;
        endcase
        for (int k = 0; k < NCHIP; k++) begin
            if (host_addr == bank_addr(k, 0)) host_rdata = cfg_q[k];
            if (host_addr == bank_addr(k, 1)) host_rdata = onoff_q[k];
            if (host_addr == bank_addr(k, 2)) host_rdata = cyc_q[k];
            for (int j = 0; j < NDCYC; j++)
                if (host_addr == bank_addr(k, 3 + j)) host_rdata = dcyc_q[k][j];
        end
    end

    AST_READY_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> host_sel);                                      // R5
    AST_START_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (ctrl_q[CB_EN] && !ctrl_q[CB_BYP]));         // R8
    AST_FD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fd_q |=> !fd_q);                                               // R9
    AST_FD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fd_q |-> !busy_q);                                             // R9
endmodule

// File: rtl/rfb_bridge.sv
// Top of the remote framebuffer command bridge: ties the register file to the
// panel sequencer. Assumes one host access at a time, held until host_ready.
module rfb_bridge import rfb_pkg::*; #(
    parameter int NCHIP  = 2,
    parameter int LINE_W = 11,
    parameter int SYNC_W = 16,
    parameter int NDCYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [RFB_AW-1:0] host_addr,
    input  logic [RFB_DW-1:0] host_wdata,
    output logic [RFB_DW-1:0] host_rdata,
    output logic              host_ready,
    output logic [NCHIP-1:0]  pnl_cs,
    output logic              pnl_a0,
    output logic              pnl_wr,
    output logic              pnl_rd,
    output logic [RFB_PW-1:0] pnl_wdata,
    input  logic [RFB_PW-1:0] pnl_rdata,
    input  logic [NCHIP-1:0]  pnl_ack,
    output logic              frame_done
);
    logic             op_start, op_done;
    pnl_op_t          op;
    logic [NCHIP-1:0] op_mask, chip_en;

    rfb_regfile #(.NCHIP(NCHIP), .LINE_W(LINE_W), .SYNC_W(SYNC_W), .NDCYC(NDCYC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .op_start(op_start), .op_out(op), .op_mask(op_mask), .op_done(op_done),
        .op_rdata(pnl_rdata), .chip_en(chip_en), .frame_done(frame_done)
    );

    rfb_panel_if #(.NCHIP(NCHIP)) u_panel (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_in(op), .mask_in(op_mask), .op_done(op_done),
        .pnl_cs(pnl_cs), .pnl_a0(pnl_a0), .pnl_wr(pnl_wr), .pnl_rd(pnl_rd),
        .pnl_wdata(pnl_wdata), .pnl_ack(pnl_ack)
    );

    AST_CS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|pnl_cs) |-> ((pnl_cs & ~chip_en) == '0));                    // R3
endmodule

// File: tb/rfb_bridge_tb.sv
module rfb_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic [1:0]  pnl_cs;
    logic        pnl_a0, pnl_wr, pnl_rd, frame_done;
    logic [15:0] pnl_wdata;
    logic [15:0] pnl_rdata = '0;
    logic [1:0]  pnl_ack = '0;

    int n_chk = 0, n_fail = 0, fd_cnt = 0, lat = 0;
    int nlg [2];
    int dly [2];
    int slow [2];
    logic [17:0] lg [2][8];
    logic [15:0] rdv [2];
    logic [15:0] rx_exp;

    always #4 clk = ~clk;

    rfb_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .pnl_cs(pnl_cs), .pnl_a0(pnl_a0), .pnl_wr(pnl_wr),
        .pnl_rd(pnl_rd), .pnl_wdata(pnl_wdata), .pnl_rdata(pnl_rdata),
        .pnl_ack(pnl_ack), .frame_done(frame_done)
    );

    // Two panel controller models: log each word and acknowledge after a delay.
    initial begin
        for (int i = 0; i < 2; i++) begin nlg[i] = 0; dly[i] = 0; slow[i] = 0; rdv[i] = '0; end
        forever begin
            @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                pnl_ack[i] = 1'b0;
                if (pnl_cs[i] && (pnl_wr || pnl_rd)) begin
                    if (dly[i] == 0) begin
                        pnl_ack[i] = 1'b1;
                        if (pnl_rd) pnl_rdata = rdv[i];
                        if (nlg[i] < 8) lg[i][nlg[i]] = {pnl_rd, pnl_a0, pnl_rd ? rdv[i] : pnl_wdata};
                        nlg[i]++;
                        dly[i] = $urandom_range(0, 2) + slow[i];
                    end else begin
                        dly[i]--;
                    end
                end
            end
        end
    end

    initial forever begin @(negedge clk); if (frame_done) fd_cnt++; end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input int a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = 5'(a); host_wdata = d; lat = 0;
        #1;
        while (!host_ready) begin @(negedge clk); #1; lat++; end
        @(posedge clk); #1;
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hr(input int a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = 5'(a);
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        d = host_rdata;
        @(posedge clk); #1;
        host_sel = 1'b0;
    endtask

    task automatic rchk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        hr(a, v);
        chk(tag, v, exp);
    endtask

    // Expected log entries for chip i after an operation (op 0 cmd .. 4 read-status).
    function automatic int exp_cnt(input int op, input logic [1:0] m, input int i);
        int sel;
        sel = m[0] ? 0 : (m[1] ? 1 : -1);
        if (op <= 1) return m[i] ? 1 : 0;
        if (op == 2) return m[i] ? 2 : 0;
        return (sel == i) ? 1 : 0;
    endfunction

    function automatic logic [17:0] exp_ent(input int op, input logic [31:0] d, input int i, input int k);
        if (op == 0) return {1'b0, 1'b0, d[15:0]};
        if (op == 1) return {1'b0, 1'b1, d[15:0]};
        if (op == 2) return {1'b0, 1'b1, (k == 0) ? d[15:0] : d[31:16]};
        return {1'b1, (op == 3), rdv[i]};
    endfunction

    task automatic do_op(input string tag, input int op, input logic [1:0] m, input logic [31:0] d);
        nlg[0] = 0; nlg[1] = 0;
        hw(6 + op, d);
        for (int i = 0; i < 2; i++) begin
            chk({tag, " count"}, 32'(nlg[i]), 32'(exp_cnt(op, m, i)));
            for (int k = 0; k < exp_cnt(op, m, i); k++)
                chk({tag, " word"}, 32'(lg[i][k]), 32'(exp_ent(op, d, i, k)));
        end
        if (op >= 3 && m != 2'b00) rx_exp = m[0] ? rdv[0] : rdv[1];
    endtask

    initial begin
        int fd0;
        logic [1:0] m;
        int op;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rx_exp = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rchk("R1 rev", 0, 32'h10);
        rchk("R1 sysstat", 2, 32'h1);
        rchk("R1 ctrl", 3, 32'h2);
        rchk("R1 cfg0", 11, 32'h0031_0000);
        rchk("R1 cfg1", 17, 32'h0031_0000);
        rchk("R1 onoff0", 12, 0);
        rchk("R1 dcyc", 14, 0);
        rchk("R1 vsw", 30, 0);
        rchk("R1 pix", 4, 0);

        // R2 masks
        hw(11, 32'hffff_ffff); rchk("R2 cfg mask", 11, 32'h003f_1fff);
        hw(18, 32'hffff_ffff); rchk("R2 onoff mask", 18, 32'h3fff_ffff);
        hw(13, 32'hffff_ffff); rchk("R2 cycle mask", 13, 32'h0fff_ffff);
        hw(22, 32'hffff_ffff); rchk("R2 dcyc mask", 22, 32'h0f1f_0f1f);
        hw(5, 32'hffff_ffff);  rchk("R2 line mask", 5, 32'h7ff);
        hw(1, 32'hffff_fffd);  rchk("R2 idle mask", 1, 32'h19);
        hw(3, 32'hffff_ffe5);  rchk("R2 ctrl mask", 3, 32'h5);
        hw(31, 32'hffff_1234); rchk("R2 hsync mask", 31, 32'h1234);
        rchk("R8 bypass blocks no busy", 2, 32'h1);

        // R12 unmapped
        hw(29, 32'hffff_ffff); rchk("R12 unmapped", 29, 0);

        // R10 soft reset
        hw(1, 32'h0000_000a);
        rchk("R10 cfg0", 11, 32'h0031_0000);
        rchk("R10 ctrl", 3, 32'h2);
        rchk("R10 line", 5, 0);
        rchk("R10 idle", 1, 32'h8);
        rchk("R10 hsync", 31, 0);

        // R3 command/parameter
        hw(3, 32'h4);  do_op("R3 cmd chip0", 0, 2'b01, 32'hdead_beef);
        hw(3, 32'hc);  do_op("R3 param both", 1, 2'b11, 32'h1234_5678);
        hw(3, 32'h8);  do_op("R3 cmd chip1", 0, 2'b10, 32'h0000_a5c3);
        // R4 data split
        hw(3, 32'hc);  do_op("R4 data both", 2, 2'b11, 32'haaaa_5555);
        // R6 reads and priority
        rdv[0] = 16'h1357; rdv[1] = 16'h2468;
        do_op("R6 status prio", 4, 2'b11, 0);
        rchk("R6 rx status", 10, 32'(rx_exp));
        hw(3, 32'h8);  do_op("R6 read chip1", 3, 2'b10, 0);
        rchk("R6 rx read", 9, 32'(rx_exp));
        // R11 no chip selected
        hw(3, 32'h0);
        do_op("R11 data none", 2, 2'b00, 32'h1111_2222);
        rdv[0] = 16'h9999; do_op("R11 read none", 3, 2'b00, 0);
        rchk("R11 rx kept", 9, 32'(rx_exp));

        // R5 slow chip stalls the host
        slow[1] = 6;
        hw(3, 32'hc);  do_op("R5 slow data", 2, 2'b11, 32'h0bad_f00d);
        chk("R5 stall", 32'(lat >= 6), 32'h1);
        slow[1] = 0;

        // R7, R8, R9 armed transfer
        hw(4, 3);
        hw(3, 32'h1d);
        rchk("R8 busy set", 2, 32'h101);
        rchk("R2 ctrl after go", 3, 32'hd);
        fd0 = fd_cnt;
        do_op("R7 data 1", 2, 2'b11, 32'h1);
        do_op("R7 data 2", 2, 2'b11, 32'h2);
        rchk("R7 still busy", 2, 32'h101);
        chk("R9 no early pulse", 32'(fd_cnt - fd0), 0);
        do_op("R7 data 3", 2, 2'b11, 32'h3);
        repeat (2) @(negedge clk);
        rchk("R7 busy cleared", 2, 32'h1);
        rchk("R7 count zero", 4, 0);
        chk("R9 one pulse", 32'(fd_cnt - fd0), 1);
        do_op("R7 wrap", 2, 2'b11, 32'h4);
        rchk("R7 wrap value", 4, 32'hffff_ffff);
        repeat (2) @(negedge clk);
        chk("R9 no pulse idle", 32'(fd_cnt - fd0), 1);

        // R8 gate negatives
        hw(11, 32'h4); hw(17, 32'h4);
        hw(3, 32'h1d); rchk("R8 cfg gate", 2, 32'h1);
        hw(17, 32'h0);
        hw(3, 32'h1c); rchk("R8 enable gate", 2, 32'h1);
        hw(3, 32'h1f); rchk("R8 bypass gate", 2, 32'h1);
        hw(3, 32'h1d); rchk("R8 gate open", 2, 32'h101);
        hw(4, 1000);

        // Random mix of panel operations
        for (int it = 0; it < 60; it++) begin
            m  = 2'($urandom_range(0, 3));
            op = $urandom_range(0, 4);
            d  = $urandom;
            rdv[0] = 16'($urandom); rdv[1] = 16'($urandom);
            hw(3, 32'(m) << 2);
            do_op(op >= 3 ? "R6 rand read" : (op == 2 ? "R4 rand data" : "R3 rand cmd"), op, m, d);
            if (op >= 3) rchk("R6 rand rx", 9, 32'(rx_exp));
            if (op >= 2) hw(4, 1000);
        end
        rchk("R7 rand count", 4, 1000);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule